// File: doc/BRIEF.md
# Flag-Setting ALU with Inline Operand Shifter

This block is the data-processing datapath of a small RISC-style integer core. Each cycle it takes two 32-bit register values, a carry-in bit, an operation code and a shift request. The second operand passes through a barrel shifter before it reaches the arithmetic and logic stage. The shifter can shift left, shift right logically or arithmetically, or rotate right, all in the same cycle. The block drives a 32-bit result and a write-enable for the destination register. The write-enable is low for operations that only compare.

The negative, zero, carry and overflow flags are held in a register inside the block. An operation that sets flags updates that register on the next rising clock edge. The result and the write-enable are combinational. In a normal core the carry-in port is fed from the registered carry flag, but the block does not require this. Decode, the register file, multiply, memory access and branching belong to other blocks.

Top module: `alu_shift_flags`

## Requirements
- R1: `shift_kind` selects the operand shifter: 0 = shift left logical, 1 = shift right logical, 2 = shift right arithmetic, 3 = rotate right. For amounts 1 to 31 the shifted second operand reaches every operation, and the shifter carry is the last bit shifted out. For rotate right, the shifter carry is bit 31 of the rotated value.
- R2: A `shift_amt` of 0 passes the second operand through unchanged, for every shift kind, and the shifter carry equals `c_in`.
- R3: Op 6 (add) gives a+b and op 7 (add with carry) gives a+b+c_in. C is the carry out of bit 31 and V is the signed overflow.
- R4: Op 8 (subtract) gives a−b and op 9 (subtract with carry) gives a−b−(1−c_in). C is 1 when no borrow occurs, and V is the signed overflow.
- R5: Op 10 (reverse subtract) gives b−a, so a zero second operand gives the negation of a. C and V follow the rules of R4.
- R6: The logical ops are 0 = a AND b, 1 = a XOR b, 2 = a OR b, 3 = a AND NOT b, 4 = move b, 5 = move NOT b. Each sets C from the shifter carry and leaves V unchanged.
- R7: Op 11 sets the flags from a−b, op 12 from a+b and op 13 from a AND b. For these three, `wr_en` is 0 and `result` still shows the value the flags were taken from.
- R8: The flags update on the clock edge that follows the operation. N is result bit 31 and Z is 1 when the result is zero. An active-low reset clears all four flags.
- R9: Ops 14 and 15 are not defined. For them `result` is 0, `wr_en` is 0 and all four flags keep their values.
- R10: `wr_en` is 1 for ops 0 to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| a | input | 32 | First operand |
| b | input | 32 | Second operand, before the shifter |
| c_in | input | 1 | Carry input to the shifter and to the carry arithmetic |
| op | input | 4 | Operation code |
| shift_kind | input | 2 | Shifter mode |
| shift_amt | input | 5 | Shift or rotate distance |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write-enable |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The only state in the block is the four-bit flag register. A fault there appears on the flag outputs one edge after the operation that wrote it, so the flags are compared after every edge. A bad hold of V across logical operations, or a bad hold across undefined codes, only shows once an operation leaves V untouched. For that reason, logical operations and undefined codes are mixed in among the arithmetic ones. Faults in the shifter or the adder appear in `result` during the same cycle. The carry path can be wrong while `result` is right, and that fault only appears in `flag_c` after the next edge. To catch it, operations with a zero shift amount and operations with the largest amount are both exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;
  parameter int DW = 32;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  localparam logic [3:0] OP_AND = 4'd0;
  localparam logic [3:0] OP_EOR = 4'd1;
  localparam logic [3:0] OP_ORR = 4'd2;
  localparam logic [3:0] OP_BIC = 4'd3;
  localparam logic [3:0] OP_MOV = 4'd4;
  localparam logic [3:0] OP_MVN = 4'd5;
  localparam logic [3:0] OP_ADD = 4'd6;
  localparam logic [3:0] OP_ADC = 4'd7;
  localparam logic [3:0] OP_SUB = 4'd8;
  localparam logic [3:0] OP_SBC = 4'd9;
  localparam logic [3:0] OP_RSB = 4'd10;
  localparam logic [3:0] OP_CMP = 4'd11;
  localparam logic [3:0] OP_CMN = 4'd12;
  localparam logic [3:0] OP_TST = 4'd13;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W  = alu_pkg::DW,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [1:0]    kind,
  input  logic [SW-1:0] amt,
  input  logic          c_in,
  output logic [W-1:0]  dout,
  output logic          c_out
);
  import alu_pkg::*;

  logic [W:0]  wide;
  logic [SW:0] back_amt;

  always_comb begin
    dout     = din;
    c_out    = c_in;
    wide     = '0;
    back_amt = (SW+1)'(W) - {1'b0, amt};
    if (amt != '0) begin
      case (shift_e'(kind))
        SH_LSL: begin
          wide  = {1'b0, din} << amt;
          dout  = wide[W-1:0];
          c_out = wide[W];
        end
        SH_LSR: begin
          wide  = {din, 1'b0} >> amt;
          dout  = wide[W:1];
          c_out = wide[0];
        end
        SH_ASR: begin
          wide  = $unsigned($signed({din, 1'b0}) >>> amt);
          dout  = wide[W:1];
          c_out = wide[0];
        end
        default: begin
          dout  = (din >> amt) | (din << back_amt);
          c_out = dout[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = alu_pkg::DW
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b_sh,
  input  logic           sh_co,
  input  logic           c_in,
  input  logic           cur_v,
  input  logic [3:0]     op,
  output logic [W-1:0]   result,
  output logic           wr_en,
  output logic           flag_upd,
  output alu_pkg::flags_t flags_nxt
);
  import alu_pkg::*;

  // One shared adder: returns {overflow, carry, sum}
  function automatic logic [W+1:0] add_cv(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic ci);
    logic [W:0] s;
    logic       ov;
    s  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    ov = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
    return {ov, s};
  endfunction

  logic [W-1:0] add_x, add_y;
  logic         add_ci;
  logic [W+1:0] add_r;
  logic         is_arith;

  always_comb begin
    add_x  = a;
    add_y  = b_sh;
    add_ci = 1'b0;
    case (op)
      OP_ADC:         add_ci = c_in;
      OP_SUB, OP_CMP: begin add_y = ~b_sh; add_ci = 1'b1; end
      OP_SBC:         begin add_y = ~b_sh; add_ci = c_in; end
      OP_RSB:         begin add_x = b_sh; add_y = ~a; add_ci = 1'b1; end
      default: ;
    endcase
  end

  assign add_r = add_cv(add_x, add_y, add_ci);

  always_comb begin
    result   = '0;
    wr_en    = 1'b1;
    flag_upd = 1'b1;
    is_arith = 1'b0;
    case (op)
      OP_AND: result = a & b_sh;
      OP_EOR: result = a ^ b_sh;
      OP_ORR: result = a | b_sh;
      OP_BIC: result = a & ~b_sh;
      OP_MOV: result = b_sh;
      OP_MVN: result = ~b_sh;
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB: begin
        result   = add_r[W-1:0];
        is_arith = 1'b1;
      end
      OP_CMP, OP_CMN: begin
        result   = add_r[W-1:0];
        is_arith = 1'b1;
        wr_en    = 1'b0;
      end
      OP_TST: begin
        result = a & b_sh;
        wr_en  = 1'b0;
      end
      default: begin
        wr_en    = 1'b0;
        flag_upd = 1'b0;
      end
    endcase
    flags_nxt.n = result[W-1];
    flags_nxt.z = (result == '0);
    flags_nxt.c = is_arith ? add_r[W] : sh_co;
    flags_nxt.v = is_arith ? add_r[W+1] : cur_v;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  alu_pkg::flags_t nxt,
  output alu_pkg::flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/alu_shift_flags.sv
module alu_shift_flags #(
  parameter int W  = alu_pkg::DW,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          c_in,
  input  logic [3:0]    op,
  input  logic [1:0]    shift_kind,
  input  logic [SW-1:0] shift_amt,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v
);
  import alu_pkg::*;

  logic [W-1:0] sh_out;
  logic         sh_co;
  logic         flag_upd;
  flags_t       flags_nxt, flags_q;

  alu_shifter #(.W(W), .SW(SW)) u_shift (
    .din(b), .kind(shift_kind), .amt(shift_amt), .c_in(c_in),
    .dout(sh_out), .c_out(sh_co)
  );

  alu_core #(.W(W)) u_core (
    .a(a), .b_sh(sh_out), .sh_co(sh_co), .c_in(c_in), .cur_v(flags_q.v),
    .op(op), .result(result), .wr_en(wr_en), .flag_upd(flag_upd),
    .flags_nxt(flags_nxt)
  );

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd), .nxt(flags_nxt), .q(flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
endmodule

// File: rtl/alu_shift_flags_chk.sv
module alu_shift_flags_chk #(
  parameter int W  = alu_pkg::DW,
  parameter int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  b,
  input logic          c_in,
  input logic [3:0]    op,
  input logic [SW-1:0] shift_amt,
  input logic [W-1:0]  result,
  input logic          wr_en,
  input logic          flag_upd,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_c,
  input logic          flag_v
);
  // R7
  compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd11 || op == 4'd12 || op == 4'd13) |-> !wr_en);

  // R10
  data_op_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= 4'd10) |-> wr_en);

  // R8
  flag_n_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> (flag_n == $past(result[W-1])));

  // R8
  flag_z_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> (flag_z == ($past(result) == '0)));

  // R9
  undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd14) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  // R2
  zero_amt_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= 4'd5 && shift_amt == '0) |=> (flag_c == $past(c_in)));

  // R6
  logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= 4'd5) |=> $stable(flag_v));

  // R2
  move_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd4 && shift_amt == '0) |-> (result == b));
endmodule

bind alu_shift_flags alu_shift_flags_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .b(b), .c_in(c_in), .op(op),
  .shift_amt(shift_amt), .result(result), .wr_en(wr_en),
  .flag_upd(flag_upd), .flag_n(flag_n), .flag_z(flag_z),
  .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/alu_shift_flags_tb.sv
module alu_shift_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        c_in = 1'b0;
  logic [3:0]  op = 4'd14;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic [31:0] result;
  logic        wr_en, flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  logic [3:0] mflags = 4'b0000;   // model {n,z,c,v}

  always #5 clk = ~clk;

  alu_shift_flags u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c_in(c_in), .op(op),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .result(result),
    .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v)
  );

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (op=%0d kind=%0d amt=%0d)",
               tag, got, exp, op, shift_kind, shift_amt);
    end
  endtask

  // bit-at-a-time shifter model (R1, R2)
  task automatic model_shift(input logic [31:0] v, input logic [1:0] k,
                             input int n, input logic ci,
                             output logic [31:0] o, output logic co);
    o  = v;
    co = ci;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin co = o[31]; o = {o[30:0], 1'b0}; end
        2'd1: begin co = o[0];  o = {1'b0, o[31:1]}; end
        2'd2: begin co = o[0];  o = {o[31], o[31:1]}; end
        default: begin co = o[0]; o = {o[0], o[31:1]}; end
      endcase
    end
  endtask

  task automatic step(input logic [3:0] o_, input logic [31:0] a_,
                      input logic [31:0] b_, input logic ci,
                      input logic [1:0] k, input int n);
    logic [31:0] bs, er;
    logic        sc, ec, ev, ew, upd, arith;
    longint      ua, ub, sa, sb, sr;
    string       tag;
    @(negedge clk);
    op = o_; a = a_; b = b_; c_in = ci; shift_kind = k; shift_amt = 5'(n);
    model_shift(b_, k, n, ci, bs, sc);
    ua = longint'(a_); ub = longint'(bs);
    sa = longint'($signed(a_)); sb = longint'($signed(bs));
    er = '0; ew = 1'b1; upd = 1'b1; arith = 1'b1; ec = 1'b0; sr = 0;
    case (o_)
      4'd0:  begin er = a_ & bs;  arith = 0; tag = "R6"; end
      4'd1:  begin er = a_ ^ bs;  arith = 0; tag = "R6"; end
      4'd2:  begin er = a_ | bs;  arith = 0; tag = "R6"; end
      4'd3:  begin er = a_ & ~bs; arith = 0; tag = "R6"; end
      4'd4:  begin er = bs;       arith = 0; tag = (n == 0) ? "R2" : "R1"; end
      4'd5:  begin er = ~bs;      arith = 0; tag = "R6"; end
      4'd6, 4'd12: begin
        er = 32'(ua + ub); ec = (ua + ub) > 64'hFFFF_FFFF; sr = sa + sb;
        tag = (o_ == 4'd6) ? "R3" : "R7"; ew = (o_ == 4'd6);
      end
      4'd7: begin
        er = 32'(ua + ub + ci); ec = (ua + ub + ci) > 64'hFFFF_FFFF;
        sr = sa + sb + ci; tag = "R3";
      end
      4'd8, 4'd11: begin
        er = 32'(ua - ub); ec = ua >= ub; sr = sa - sb;
        tag = (o_ == 4'd8) ? "R4" : "R7"; ew = (o_ == 4'd8);
      end
      4'd9: begin
        er = 32'(ua - ub - (1 - ci)); ec = ua >= ub + (1 - ci);
        sr = sa - sb - (1 - ci); tag = "R4";
      end
      4'd10: begin er = 32'(ub - ua); ec = ub >= ua; sr = sb - sa; tag = "R5"; end
      4'd13: begin er = a_ & bs; arith = 0; ew = 0; tag = "R7"; end
      default: begin ew = 0; upd = 0; arith = 0; tag = "R9"; end
    endcase
    ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    #1;
    check({tag, " result"}, result, er);
    check((o_ <= 4'd10) ? "R10 wr_en" : (o_ <= 4'd13 ? "R7 wr_en" : "R9 wr_en"),
          {31'b0, wr_en}, {31'b0, ew});
    if (upd)
      mflags = {er[31], er == 32'b0, arith ? ec : sc, arith ? ev : mflags[0]};
    @(posedge clk);
    #1;
    check(upd ? {"R8 flags ", tag} : "R9 flags held",
          {28'b0, flag_n, flag_z, flag_c, flag_v}, {28'b0, mflags});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset flags", {28'b0, flag_n, flag_z, flag_c, flag_v}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 shifter kinds at boundaries
    for (int k = 0; k < 4; k++) begin
      step(4'd4, 32'h0, 32'h8000_0001, 1'b1, 2'(k), 0);
      step(4'd4, 32'h0, 32'h8000_0001, 1'b0, 2'(k), 1);
      step(4'd4, 32'h0, 32'hC000_0003, 1'b0, 2'(k), 31);
      step(4'd4, 32'h0, 32'h0000_0000, 1'b1, 2'(k), 0);
    end
    // R3 add overflow / carry
    step(4'd6, 32'h7FFF_FFFF, 32'h1, 1'b0, 2'd0, 0);
    step(4'd6, 32'hFFFF_FFFF, 32'h1, 1'b0, 2'd0, 0);
    step(4'd7, 32'hFFFF_FFFE, 32'h1, 1'b1, 2'd0, 0);
    // R4 subtract and borrow
    step(4'd8, 32'h5, 32'h5, 1'b0, 2'd0, 0);
    step(4'd8, 32'h8000_0000, 32'h1, 1'b0, 2'd0, 0);
    step(4'd9, 32'h5, 32'h5, 1'b0, 2'd0, 0);
    step(4'd9, 32'h5, 32'h5, 1'b1, 2'd0, 0);
    // R5 negate
    step(4'd10, 32'h5, 32'h0, 1'b0, 2'd0, 0);
    step(4'd10, 32'h3, 32'h10, 1'b0, 2'd0, 0);
    // R6 V hold through logic ops after an overflow
    step(4'd6, 32'h7FFF_FFFF, 32'h1, 1'b0, 2'd0, 0);
    step(4'd3, 32'hFFFF_00FF, 32'h0000_0F0F, 1'b1, 2'd1, 4);
    step(4'd5, 32'h0, 32'h0000_00FF, 1'b0, 2'd3, 8);
    // R7 compares
    step(4'd11, 32'h10, 32'h10, 1'b0, 2'd0, 0);
    step(4'd12, 32'hFFFF_FFFF, 32'h1, 1'b0, 2'd0, 0);
    step(4'd13, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1, 2'd0, 0);
    // R9 undefined codes hold flags
    step(4'd6, 32'h8000_0000, 32'h8000_0000, 1'b0, 2'd0, 0);
    step(4'd14, 32'h0, 32'h0, 1'b0, 2'd0, 0);
    step(4'd15, 32'h0, 32'h0, 1'b1, 2'd0, 0);
    // mixed random traffic
    for (int i = 0; i < 600; i++)
      step(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom),
           2'($urandom), ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 31)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule